// File: doc/BRIEF.md
# UART Power-Save Duty-Cycle Controller

This block decides, cycle by cycle, whether a serial port toward a host terminal is powered and listening. In always-on mode the port stays enabled permanently. In cyclic mode the port is opened for a short listening window and then shut for a long sleep. The sleep is either a fixed free-running interval or, when a 2G network is registered, a minimum gap that ends only at the next paging strobe. Received characters and outbound traffic keep the port open. When flow control is off, a character that arrives during sleep starts a wake-up that takes a fixed number of milliseconds.

The controller drives three signals: the port enable, a clear-to-send indication for the host, and an active-mode request for the rest of the device. It also drives a release strobe that lets outbound data leave only when the host can take it. All durations are counted in milliseconds from an internal divider. The divider is set by the clock-per-millisecond parameter, so a simulation can shorten every interval by the same factor.

Top module: `ups_ctrl`

## Requirements
- R1: Out of reset, and at all times while `cyclic_mode_i` is 0, `uart_en_o`, `cts_on_o` and `active_req_o` are 1, whatever the other inputs do.
- R2: In cyclic mode, with `net_ctx_i` not equal to 2'b10 (2'b00 = none, 2'b01 = LTE, 2'b11 = treated as none), an idle window stays open for ON_MS ticks. The port is then disabled for OFF_MS ticks and reopens without any paging strobe.
- R3: In cyclic mode with `net_ctx_i` = 2'b10 (2G), an idle window is followed by a disabled gap of GAP_MS ticks. The port then reopens only on the first `paging_strobe_i` after the gap. Strobes inside the gap have no effect, and the free-running OFF_MS schedule does not reopen the port.
- R4: A `rx_char_i` pulse while the window is open restarts the window with `idle_tmo_ms_i` ticks, sampled at that pulse. `uart_en_o` and `active_req_o` stay 1 until that count expires.
- R5: An `idle_tmo_ms_i` of 0 makes a restart use ON_MS ticks.
- R6: A `tx_pending_i` of 1 during sleep enables the port in the next cycle. The window never closes while `tx_pending_i` is 1, and it closes within one tick after the pending flag clears once the window time has elapsed.
- R7: With `hw_fc_en_i` = 0, a `rx_char_i` pulse during sleep raises `active_req_o` in the next cycle. `uart_en_o` stays 0 for WAKE_MS ticks, and the port then opens for a window of `idle_tmo_ms_i` ticks.
- R8: With `hw_fc_en_i` = 1, a `rx_char_i` pulse during sleep is ignored: `uart_en_o` and `active_req_o` stay 0.
- R9: `tx_release_o` is 1 only while `uart_en_o` is 1 and either `hw_fc_en_i` is 0 or `rts_on_i` is 1.
- R10: `cts_on_o` equals `uart_en_o` at every cycle.
- R11: Setting `cyclic_mode_i` to 1 starts the first cyclic window at the next millisecond tick. Setting it to 0 forces all three enables to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyclic_mode_i | input | 1 | 0 = always on, 1 = cyclic power saving |
| net_ctx_i | input | 2 | Registration context: 00 none, 01 LTE, 10 2G, 11 as none |
| paging_strobe_i | input | 1 | One-cycle pulse at each paging reception |
| rx_char_i | input | 1 | One-cycle pulse per character seen on the receive line |
| hw_fc_en_i | input | 1 | Hardware flow control enabled |
| rts_on_i | input | 1 | Host ready-to-receive line is ON |
| tx_pending_i | input | 1 | Device has data queued for the host |
| idle_tmo_ms_i | input | TMO_W | Inactivity timeout in ms after a character |
| uart_en_o | output | 1 | Port enabled |
| cts_on_o | output | 1 | Clear-to-send toward the host |
| active_req_o | output | 1 | Request to keep the device in active mode |
| tx_release_o | output | 1 | Outbound data may be sent now |

## Verification
A wrong state shows up as a window length or a sleep length that is off by whole milliseconds. The bench therefore measures each interval in clock cycles and compares it with a narrow band, and a miscounted reload is visible within one window. A wrong transition during sleep shows up in the very next cycle: an enable that rises on a gap strobe, on a character under flow control, or too early after a wake. The bench samples each of these one cycle after the stimulus. A stuck pending flag or a wrong release gate is seen on `tx_release_o` in the same cycle that `rts_on_i` changes.

// File: rtl/ups_pkg.sv
package ups_pkg;

    typedef enum logic [1:0] {
        CTX_NONE = 2'b00,
        CTX_LTE  = 2'b01,
        CTX_2G   = 2'b10,
        CTX_RSVD = 2'b11
    } net_ctx_e;

    typedef enum logic [2:0] {
        ST_ALWAYS,
        ST_WINDOW,
        ST_SLEEP,
        ST_PAGE_WAIT,
        ST_WAKE
    } ps_state_e;

    typedef struct packed {
        logic port_on;
        logic active;
    } ps_out_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic ctx_paged(input logic [1:0] ctx);
        return ctx == CTX_2G;
    endfunction

    function automatic ps_out_t decode_state(input ps_state_e st);
        ps_out_t o;
        o.port_on = (st == ST_ALWAYS) || (st == ST_WINDOW);
        o.active  = o.port_on || (st == ST_WAKE);
        return o;
    endfunction

endpackage

// File: rtl/ups_tick_div.sv
module ups_tick_div #(
    parameter int unsigned CLK_PER_MS = 250000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned DW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_MS - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)               div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    generate
        if (CLK_PER_MS > 1) begin : g_gap
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ups_duty_fsm.sv
module ups_duty_fsm
    import ups_pkg::*;
#(
    parameter int unsigned ON_MS   = 20,
    parameter int unsigned OFF_MS  = 2500,
    parameter int unsigned GAP_MS  = 2000,
    parameter int unsigned WAKE_MS = 20,
    parameter int unsigned TMO_W   = 16,
    parameter int unsigned CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cyclic,
    input  logic [1:0]       net_ctx,
    input  logic             paging,
    input  logic             rx_char,
    input  logic             hw_fc_en,
    input  logic             tx_pending,
    input  logic [TMO_W-1:0] idle_tmo,
    output logic             uart_en,
    output logic             active_req
);
    localparam logic [CNT_W-1:0] ON_LD   = CNT_W'(ON_MS);
    localparam logic [CNT_W-1:0] OFF_LD  = CNT_W'(OFF_MS);
    localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_MS);
    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_MS);

    ps_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] win_ld, sleep_ld;
    logic             wake_ok;
    ps_out_t          outs;

    assign win_ld   = (idle_tmo == '0) ? ON_LD : CNT_W'(idle_tmo);
    assign sleep_ld = ctx_paged(net_ctx) ? GAP_LD : OFF_LD;
    assign wake_ok  = rx_char && !hw_fc_en;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!cyclic) begin
            st_d  = ST_ALWAYS;
            cnt_d = '0;
        end else begin
            case (st_q)
                ST_ALWAYS: begin
                    if (tick) begin
                        st_d  = ST_WINDOW;
                        cnt_d = ON_LD;
                    end
                end
                ST_WINDOW: begin
                    if (rx_char) begin
                        cnt_d = win_ld;
                    end else if (tick) begin
                        if (cnt_q > 1)
                            cnt_d = cnt_q - 1'b1;
                        else if (!tx_pending) begin
                            st_d  = ST_SLEEP;
                            cnt_d = sleep_ld;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (tx_pending) begin
                        st_d  = ST_WINDOW;
                        cnt_d = ON_LD;
                    end else if (wake_ok) begin
                        st_d  = ST_WAKE;
                        cnt_d = WAKE_LD;
                    end else if (tick) begin
                        if (cnt_q > 1)
                            cnt_d = cnt_q - 1'b1;
                        else if (ctx_paged(net_ctx)) begin
                            st_d  = ST_PAGE_WAIT;
                            cnt_d = '0;
                        end else begin
                            st_d  = ST_WINDOW;
                            cnt_d = ON_LD;
                        end
                    end
                end
                ST_PAGE_WAIT: begin
                    if (tx_pending || paging) begin
                        st_d  = ST_WINDOW;
                        cnt_d = ON_LD;
                    end else if (wake_ok) begin
                        st_d  = ST_WAKE;
                        cnt_d = WAKE_LD;
                    end
                end
                ST_WAKE: begin
                    if (tick) begin
                        if (cnt_q > 1)
                            cnt_d = cnt_q - 1'b1;
                        else begin
                            st_d  = ST_WINDOW;
                            cnt_d = win_ld;
                        end
                    end
                end
                default: begin
                    st_d  = ST_ALWAYS;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_ALWAYS;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign outs       = decode_state(st_q);
    assign uart_en    = outs.port_on;
    assign active_req = outs.active;

    // R11
    mode_on_chk: assert property (@(posedge clk) disable iff (rst)
        !cyclic |=> (uart_en && active_req));

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(uart_en) |-> !$past(tx_pending));

    // R3
    page_align_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(uart_en) && $past(st_q == ST_PAGE_WAIT) && $past(cyclic))
            |-> $past(paging || tx_pending));

    // R8
    fc_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLEEP && cyclic && hw_fc_en && rx_char && !tx_pending && !tick)
            |=> (st_q == ST_SLEEP && !active_req));

    // R2
    cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WINDOW || st_q == ST_SLEEP || st_q == ST_WAKE) |-> (cnt_q != '0));

endmodule

// File: rtl/ups_flow_gate.sv
module ups_flow_gate (
    input  logic clk,
    input  logic rst,
    input  logic uart_en,
    input  logic hw_fc_en,
    input  logic rts_on,
    output logic cts_on,
    output logic tx_release
);
    logic host_ready;

    assign host_ready = !hw_fc_en || rts_on;
    assign cts_on     = uart_en;
    assign tx_release = uart_en && host_ready;

    // R9
    rel_host_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_release && hw_fc_en) |-> rts_on);

endmodule

// File: rtl/ups_ctrl.sv
module ups_ctrl
    import ups_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 250000,
    parameter int unsigned ON_MS      = 20,
    parameter int unsigned OFF_MS     = 2500,
    parameter int unsigned GAP_MS     = 2000,
    parameter int unsigned WAKE_MS    = 20,
    parameter int unsigned TMO_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyclic_mode_i,
    input  logic [1:0]       net_ctx_i,
    input  logic             paging_strobe_i,
    input  logic             rx_char_i,
    input  logic             hw_fc_en_i,
    input  logic             rts_on_i,
    input  logic             tx_pending_i,
    input  logic [TMO_W-1:0] idle_tmo_ms_i,
    output logic             uart_en_o,
    output logic             cts_on_o,
    output logic             active_req_o,
    output logic             tx_release_o
);
    localparam int unsigned MAX_MS = umax(umax(umax(ON_MS, OFF_MS), umax(GAP_MS, WAKE_MS)),
                                          (2 ** TMO_W) - 1);
    localparam int unsigned CNT_W  = $clog2(MAX_MS + 1);

    logic ms_tick;

    ups_tick_div #(
        .CLK_PER_MS(CLK_PER_MS)
    ) u_div (
        .clk (clk),
        .rst (rst),
        .tick(ms_tick)
    );

    ups_duty_fsm #(
        .ON_MS  (ON_MS),
        .OFF_MS (OFF_MS),
        .GAP_MS (GAP_MS),
        .WAKE_MS(WAKE_MS),
        .TMO_W  (TMO_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (ms_tick),
        .cyclic    (cyclic_mode_i),
        .net_ctx   (net_ctx_i),
        .paging    (paging_strobe_i),
        .rx_char   (rx_char_i),
        .hw_fc_en  (hw_fc_en_i),
        .tx_pending(tx_pending_i),
        .idle_tmo  (idle_tmo_ms_i),
        .uart_en   (uart_en_o),
        .active_req(active_req_o)
    );

    ups_flow_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .uart_en   (uart_en_o),
        .hw_fc_en  (hw_fc_en_i),
        .rts_on    (rts_on_i),
        .cts_on    (cts_on_o),
        .tx_release(tx_release_o)
    );

    // R10
    cts_track_chk: assert property (@(posedge clk) disable iff (rst)
        cts_on_o == uart_en_o);

    // R9
    rel_port_chk: assert property (@(posedge clk) disable iff (rst)
        tx_release_o |-> uart_en_o);

endmodule

// File: tb/ups_ctrl_tb.sv
module ups_ctrl_tb;

    localparam int unsigned TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cyclic_mode_i = 1'b0;
    logic [1:0]       net_ctx_i = 2'b00;
    logic             paging_strobe_i = 1'b0;
    logic             rx_char_i = 1'b0;
    logic             hw_fc_en_i = 1'b0;
    logic             rts_on_i = 1'b0;
    logic             tx_pending_i = 1'b0;
    logic [TMO_W-1:0] idle_tmo_ms_i = '0;
    logic             uart_en_o, cts_on_o, active_req_o, tx_release_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ups_ctrl #(
        .CLK_PER_MS(4),
        .TMO_W     (TMO_W)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .cyclic_mode_i  (cyclic_mode_i),
        .net_ctx_i      (net_ctx_i),
        .paging_strobe_i(paging_strobe_i),
        .rx_char_i      (rx_char_i),
        .hw_fc_en_i     (hw_fc_en_i),
        .rts_on_i       (rts_on_i),
        .tx_pending_i   (tx_pending_i),
        .idle_tmo_ms_i  (idle_tmo_ms_i),
        .uart_en_o      (uart_en_o),
        .cts_on_o       (cts_on_o),
        .active_req_o   (active_req_o),
        .tx_release_o   (tx_release_o)
    );

    // {hw_fc, rts, tx_pending, rx_char, paging, exp_en, exp_cts, exp_act, exp_rel}
    localparam logic [8:0] MODE0_VEC [8] = '{
        9'b00000_1111,
        9'b10000_1110,
        9'b11000_1111,
        9'b10110_1110,
        9'b01011_1111,
        9'b11111_1111,
        9'b10001_1110,
        9'b00100_1111
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wait_en(input logic val, input int max, output int n);
        n = 0;
        while (uart_en_o !== val && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_rx();
        rx_char_i = 1'b1;
        @(negedge clk);
        rx_char_i = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset uart_en", uart_en_o, 1);
        chk("R1 reset active", active_req_o, 1);
        chk("R10 reset cts", cts_on_o, 1);

        // R1 R9 mode-0 table
        for (int i = 0; i < 8; i++) begin
            {hw_fc_en_i, rts_on_i, tx_pending_i, rx_char_i, paging_strobe_i} = MODE0_VEC[i][8:4];
            @(negedge clk);
            chk($sformatf("R1 vec%0d uart_en", i), uart_en_o, MODE0_VEC[i][3]);
            chk($sformatf("R10 vec%0d cts", i), cts_on_o, MODE0_VEC[i][2]);
            chk($sformatf("R1 vec%0d active", i), active_req_o, MODE0_VEC[i][1]);
            chk($sformatf("R9 vec%0d release", i), tx_release_o, MODE0_VEC[i][0]);
        end
        {hw_fc_en_i, rts_on_i, tx_pending_i, rx_char_i, paging_strobe_i} = '0;
        @(negedge clk);

        // R11 R2 first cyclic window then free-running sleep
        cyclic_mode_i = 1'b1;
        wait_en(1'b0, 200, n);
        chk_rng("R11 R2 first window cycles", n, 76, 88);
        chk("R2 sleep active", active_req_o, 0);
        chk("R10 sleep cts", cts_on_o, 0);
        chk("R9 sleep release", tx_release_o, 0);
        wait_en(1'b1, 12000, n);
        chk_rng("R2 sleep cycles", n, 9992, 10008);

        // R4 character extends window with sampled timeout
        idle_tmo_ms_i = 16'd50;
        repeat (40) @(negedge clk);
        pulse_rx();
        repeat (119) @(negedge clk);
        chk("R4 extended uart_en", uart_en_o, 1);
        chk("R4 extended active", active_req_o, 1);
        wait_en(1'b0, 400, n);
        chk_rng("R4 remaining window cycles", n, 72, 88);

        // R5 zero timeout falls back to base window
        wait_en(1'b1, 12000, n);
        idle_tmo_ms_i = '0;
        repeat (40) @(negedge clk);
        pulse_rx();
        wait_en(1'b0, 200, n);
        chk_rng("R5 base restart cycles", n, 72, 88);

        // R8 character ignored under flow control
        hw_fc_en_i = 1'b1;
        repeat (100) @(negedge clk);
        pulse_rx();
        repeat (2) @(negedge clk);
        chk("R8 uart_en stays off", uart_en_o, 0);
        chk("R8 active stays off", active_req_o, 0);

        // R7 wake by character without flow control
        hw_fc_en_i = 1'b0;
        idle_tmo_ms_i = 16'd30;
        pulse_rx();
        chk("R7 wake active", active_req_o, 1);
        chk("R7 wake uart_en off", uart_en_o, 0);
        wait_en(1'b1, 200, n);
        chk_rng("R7 wake latency cycles", n, 70, 88);
        wait_en(1'b0, 300, n);
        chk_rng("R7 post-wake window cycles", n, 112, 128);

        // R6 R9 pending transmit during sleep
        hw_fc_en_i = 1'b1;
        rts_on_i = 1'b0;
        repeat (50) @(negedge clk);
        tx_pending_i = 1'b1;
        @(negedge clk);
        chk("R6 pending enables port", uart_en_o, 1);
        chk("R9 held while rts off", tx_release_o, 0);
        repeat (300) @(negedge clk);
        chk("R6 window held open", uart_en_o, 1);
        rts_on_i = 1'b1;
        @(negedge clk);
        chk("R9 released with rts on", tx_release_o, 1);
        net_ctx_i = 2'b10;
        tx_pending_i = 1'b0;
        wait_en(1'b0, 20, n);
        chk_rng("R6 close after pending clears", n, 1, 5);

        // R3 paging-aligned reopen in 2G context
        repeat (4000) @(negedge clk);
        paging_strobe_i = 1'b1;
        @(negedge clk);
        paging_strobe_i = 1'b0;
        chk("R3 strobe in gap ignored", uart_en_o, 0);
        repeat (5000) @(negedge clk);
        chk("R3 no reopen without strobe", uart_en_o, 0);
        chk("R3 active off awaiting strobe", active_req_o, 0);
        repeat (1500) @(negedge clk);
        chk("R3 free-running schedule unused", uart_en_o, 0);
        paging_strobe_i = 1'b1;
        @(negedge clk);
        paging_strobe_i = 1'b0;
        chk("R3 reopen on strobe", uart_en_o, 1);

        // R11 return to always-on from sleep
        wait_en(1'b0, 200, n);
        chk_rng("R3 paged window cycles", n, 76, 88);
        cyclic_mode_i = 1'b0;
        @(negedge clk);
        chk("R11 forced uart_en", uart_en_o, 1);
        chk("R11 forced active", active_req_o, 1);
        chk("R10 forced cts", cts_on_o, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule